// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a small shared-memory system. For every memory block it keeps a coherence state (not cached, read-shared, or held by a single owner) and a presence vector with one bit per processor node. Caches send it three kinds of request: read miss, write miss and write-back of a dirty block. The controller answers with targeted messages: a data reply to the requester, invalidates to the nodes that hold copies, and a fetch, or a fetch-and-invalidate, to the owner of a modified block. It also keeps the backing memory words.

It serves one request at a time, in the order the requests arrive. While a request is in progress, further requests are held off through the input ready signal. When a block is owned, the controller sends a fetch to the owner and then waits. During that wait it accepts only the owner's write-back for that same block. The written-back word goes into memory before the data reply is sent.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is not cached and has no sharers, `out_valid` is 0, `in_ready` is 1, and the memory word at block address a holds 0xA5 in bits 31:24, a in bits 3:0 and zeros in the other bits.
- R2: A read miss (`in_kind`=0) to a block that is not cached or is shared is answered in the cycle after acceptance with one data reply (`out_kind`=0) to the requester, carrying the memory word. The requester is then added to the sharers and the block becomes shared.
- R3: A write miss (`in_kind`=1) to a block that is not cached is answered in the cycle after acceptance with a data reply. The requester becomes the sole sharer and the block becomes owned.
- R4: A write miss to a shared block first sends one invalidate (`out_kind`=1) per cycle, starting in the cycle after acceptance, to each sharer other than the requester, in ascending node order. The data reply follows in the next cycle. Afterwards the requester is the sole owner. If the requester is the only sharer, the reply comes at once.
- R5: A read miss to an owned block sends a fetch (`out_kind`=2) to the owner in the cycle after acceptance and then sends nothing. The cycle after the owner's write-back is accepted, the data reply carries the written-back word. The owner and the requester are then the sharers and the block is shared.
- R6: A write miss to an owned block sends a fetch-and-invalidate (`out_kind`=3) to the owner. After the owner's write-back is accepted, memory holds the written word and the reply carries it. The requester becomes the sole owner.
- R7: A write-back (`in_kind`=2) from the owner of an owned block, arriving while the controller is idle, updates memory and makes the block not cached. No message is sent.
- R8: While the controller waits for an owner's write-back, `in_ready` is 0 for every request except a write-back from that owner to that block.
- R9: A write-back from a node that is not the owner, a write-back to a block that is not owned, and the unused request code 3 are all accepted without effect: no message is sent and neither memory nor the directory changes.
- R10: `out_addr` carries the block address of the request being served, and `out_data` is 0 on every message other than a data reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken at this clock edge when in_valid is 1 |
| in_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 unused |
| in_node | input | 2 | Sending node |
| in_addr | input | 4 | Block address |
| in_data | input | 32 | Write-back word |
| out_valid | output | 1 | Message present this cycle |
| out_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| out_node | output | 2 | Destination node |
| out_addr | output | 4 | Block address |
| out_data | output | 32 | Reply word, 0 on other messages |

## Verification
The hardest situation to reach is the wait for an owner's write-back. It needs a block driven into the owned state, a second node missing on it, and then stray traffic arriving before the right write-back. The directed part of the stimulus builds that sequence on purpose. While the controller waits, it offers a read from another node, a write-back from the wrong node and a write-back to the wrong block, and it checks that each one is held off. A pseudo-random phase then reuses four block addresses, so that owner fetches, invalidate trains and ignored write-backs keep colliding.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int NODES  = 4;
    localparam int NODE_W = $clog2(NODES);
    localparam int BLOCKS = 16;
    localparam int ADDR_W = $clog2(BLOCKS);
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REQ_RD  = 2'd0,
        REQ_WR  = 2'd1,
        REQ_WB  = 2'd2,
        REQ_NOP = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        MSG_DATA      = 2'd0,
        MSG_INV       = 2'd1,
        MSG_FETCH     = 2'd2,
        MSG_FETCH_INV = 2'd3
    } msg_e;

    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_e;

    typedef struct packed {
        blk_e              st;
        logic [NODES-1:0]  sharers;
    } dir_ent_t;

    typedef struct packed {
        req_e               kind;
        logic [NODE_W-1:0]  node;
        logic [ADDR_W-1:0]  addr;
    } req_t;

    function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
        node_bit    = '0;
        node_bit[n] = 1'b1;
    endfunction

    function automatic logic [NODE_W-1:0] lowest_node(input logic [NODES-1:0] v);
        lowest_node = '0;
        for (int i = NODES - 1; i >= 0; i--)
            if (v[i]) lowest_node = NODE_W'(i);
    endfunction

    function automatic logic [WORD_W-1:0] boot_word(input logic [ADDR_W-1:0] a);
        boot_word = {8'hA5, {(WORD_W - 8 - ADDR_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/dir_state_array.sv
module dir_state_array
    import dir_pkg::*;
#(
    parameter int ENTRIES = BLOCKS,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rd_addr,
    output dir_ent_t       rd_ent,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  dir_ent_t       wr_ent
);
    dir_ent_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= '{st: BLK_UNC, sharers: '0};
        end else if (wr_en) begin
            tbl[wr_addr] <= wr_ent;
        end
    end

    assign rd_ent = tbl[rd_addr];

    // R6
    exc_single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ent.st == BLK_EXC) |-> ($countones(rd_ent.sharers) == 1));

    // R7
    unc_no_sharer_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ent.st == BLK_UNC) |-> (rd_ent.sharers == '0));

    // R2
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ent.st == BLK_SHR) |-> (rd_ent.sharers != '0));
endmodule

// File: rtl/dir_word_mem.sv
module dir_word_mem
    import dir_pkg::*;
#(
    parameter int DEPTH = BLOCKS,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                words[i] <= DW'(boot_word(ADDR_W'(i)));
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/dir_inval_seq.sv
module dir_inval_seq
    import dir_pkg::*;
#(
    parameter int N  = NODES,
    parameter int NW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [N-1:0]   load_vec,
    input  logic           step,
    output logic [NW-1:0]  cur_node,
    output logic           last
);
    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0] pend;
    logic [N-1:0] pend_rest;

    assign pend_rest = pend & (pend - ONE);

    always_ff @(posedge clk) begin
        if (rst)       pend <= '0;
        else if (load) pend <= load_vec;
        else if (step) pend <= pend_rest;
    end

    always_comb begin
        cur_node = '0;
        for (int i = N - 1; i >= 0; i--)
            if (pend[i]) cur_node = NW'(i);
    end

    assign last = (pend_rest == '0);

    // R4
    step_has_target_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (pend != '0));

    // R4
    step_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ($countones(pend) + 1 == $countones($past(pend))));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [1:0]   in_kind,
    input  logic [1:0]   in_node,
    input  logic [3:0]   in_addr,
    input  logic [31:0]  in_data,
    output logic         out_valid,
    output logic [1:0]   out_kind,
    output logic [1:0]   out_node,
    output logic [3:0]   out_addr,
    output logic [31:0]  out_data
);
    typedef enum logic [2:0] {
        S_IDLE, S_INV, S_FETCH, S_WAIT, S_REPLY
    } ctl_e;

    ctl_e               st, st_nxt;
    req_t               cur;
    logic [NODE_W-1:0]  owner_q;
    req_e               kind_in;

    dir_ent_t           ent, dir_wd;
    logic               dir_we;
    logic [ADDR_W-1:0]  acc_addr;

    logic               mem_we;
    logic [WORD_W-1:0]  mem_rd;

    logic               inv_load, inv_step, inv_last;
    logic [NODES-1:0]   inv_vec;
    logic [NODE_W-1:0]  inv_node;

    assign kind_in  = req_e'(in_kind);
    assign acc_addr = (st == S_IDLE) ? in_addr : cur.addr;

    dir_state_array #(.ENTRIES(BLOCKS)) u_dir (
        .clk(clk), .rst(rst),
        .rd_addr(acc_addr), .rd_ent(ent),
        .wr_en(dir_we), .wr_addr(acc_addr), .wr_ent(dir_wd)
    );

    dir_word_mem #(.DEPTH(BLOCKS), .DW(WORD_W)) u_mem (
        .clk(clk), .rst(rst),
        .rd_addr(cur.addr), .rd_data(mem_rd),
        .wr_en(mem_we), .wr_addr(acc_addr), .wr_data(in_data)
    );

    dir_inval_seq #(.N(NODES)) u_inv (
        .clk(clk), .rst(rst),
        .load(inv_load), .load_vec(inv_vec), .step(inv_step),
        .cur_node(inv_node), .last(inv_last)
    );

    always_comb begin
        case (st)
            S_IDLE:  in_ready = 1'b1;
            S_WAIT:  in_ready = in_valid && (kind_in == REQ_WB) &&
                                (in_node == owner_q) && (in_addr == cur.addr);
            default: in_ready = 1'b0;
        endcase
    end

    always_comb begin
        st_nxt   = st;
        dir_we   = 1'b0;
        dir_wd   = ent;
        mem_we   = 1'b0;
        inv_load = 1'b0;
        inv_vec  = '0;
        inv_step = 1'b0;
        case (st)
            S_IDLE: if (in_valid) begin
                case (kind_in)
                    REQ_RD: begin
                        if (ent.st == BLK_EXC) begin
                            st_nxt = S_FETCH;
                        end else begin
                            dir_we = 1'b1;
                            dir_wd = '{st: BLK_SHR, sharers: ent.sharers | node_bit(in_node)};
                            st_nxt = S_REPLY;
                        end
                    end
                    REQ_WR: begin
                        if (ent.st == BLK_EXC) begin
                            st_nxt = S_FETCH;
                        end else begin
                            dir_we   = 1'b1;
                            dir_wd   = '{st: BLK_EXC, sharers: node_bit(in_node)};
                            inv_vec  = ent.sharers & ~node_bit(in_node);
                            inv_load = 1'b1;
                            st_nxt   = (inv_vec != '0) ? S_INV : S_REPLY;
                        end
                    end
                    REQ_WB: begin
                        if (ent.st == BLK_EXC && ent.sharers[in_node]) begin
                            mem_we = 1'b1;
                            dir_we = 1'b1;
                            dir_wd = '{st: BLK_UNC, sharers: '0};
                        end
                    end
                    default: ;
                endcase
            end
            S_INV: begin
                inv_step = 1'b1;
                if (inv_last) st_nxt = S_REPLY;
            end
            S_FETCH: st_nxt = S_WAIT;
            S_WAIT: if (in_ready) begin
                mem_we = 1'b1;
                dir_we = 1'b1;
                if (cur.kind == REQ_RD)
                    dir_wd = '{st: BLK_SHR, sharers: node_bit(owner_q) | node_bit(cur.node)};
                else
                    dir_wd = '{st: BLK_EXC, sharers: node_bit(cur.node)};
                st_nxt = S_REPLY;
            end
            S_REPLY: st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cur     <= '{kind: REQ_NOP, node: '0, addr: '0};
            owner_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == S_IDLE && in_valid) begin
                cur     <= '{kind: kind_in, node: in_node, addr: in_addr};
                owner_q <= lowest_node(ent.sharers);
            end
        end
    end

    always_comb begin
        out_valid = (st == S_INV) || (st == S_FETCH) || (st == S_REPLY);
        out_addr  = cur.addr;
        out_data  = '0;
        out_kind  = MSG_DATA;
        out_node  = cur.node;
        case (st)
            S_INV: begin
                out_kind = MSG_INV;
                out_node = inv_node;
            end
            S_FETCH: begin
                out_kind = (cur.kind == REQ_WR) ? MSG_FETCH_INV : MSG_FETCH;
                out_node = owner_q;
            end
            S_REPLY: out_data = mem_rd;
            default: ;
        endcase
    end

    // R5
    fetch_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_kind == MSG_FETCH || out_kind == MSG_FETCH_INV)) |=> !out_valid);

    // R4
    inv_not_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_INV) |-> (out_node != cur.node));

    // R2
    reply_then_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_DATA) |=> (!out_valid && in_ready));

    // R8
    wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && in_valid && kind_in != REQ_WB) |-> !in_ready);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(out_addr));
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = '0;
    logic [1:0]  in_node = '0;
    logic [3:0]  in_addr = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [1:0]  out_node;
    logic [3:0]  out_addr;
    logic [31:0] out_data;

    always #(CLK_T / 2) clk = ~clk;

    dir_home_ctrl uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_node(in_node), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_node(out_node),
        .out_addr(out_addr), .out_data(out_data)
    );

    int total = 0;
    int bad   = 0;
    bit mon_on = 0;
    string cur_tag = "R1";

    // reference model: 0 uncached, 1 shared, 2 owned
    int          m_st  [16];
    bit [3:0]    m_sh  [16];
    logic [31:0] m_mem [16];
    bit          m_wait = 0;
    int          w_kind, w_node, w_addr, w_owner;

    int          qk [$];
    int          qn [$];
    int          qa [$];
    logic [31:0] qd [$];
    string       qt [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] boot(input int a);
        return 32'hA500_0000 | 32'(a & 15);
    endfunction

    function automatic int low_bit(input bit [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic bit exp_ready(input int k, input int n, input int a);
        if (!m_wait) return 1'b1;
        return (k == 2) && (n == w_owner) && (a == w_addr);
    endfunction

    function automatic void push(input int k, input int n, input int a,
                                 input logic [31:0] d, input string t);
        qk.push_back(k); qn.push_back(n); qa.push_back(a); qd.push_back(d); qt.push_back(t);
    endfunction

    function automatic void model_accept(input int k, input int n, input int a,
                                         input logic [31:0] d, input string t);
        if (m_wait) begin
            m_mem[a] = d;
            if (w_kind == 0) begin
                m_st[a] = 1;
                m_sh[a] = 4'(1 << w_owner) | 4'(1 << w_node);
            end else begin
                m_st[a] = 2;
                m_sh[a] = 4'(1 << w_node);
            end
            push(0, w_node, a, m_mem[a], t);
            m_wait = 0;
            return;
        end
        case (k)
            0, 1: begin
                if (m_st[a] == 2) begin
                    m_wait  = 1;
                    w_kind  = k;
                    w_node  = n;
                    w_addr  = a;
                    w_owner = low_bit(m_sh[a]);
                    push(k == 0 ? 2 : 3, w_owner, a, 32'h0, t);
                end else if (k == 0) begin
                    m_st[a] = 1;
                    m_sh[a] = m_sh[a] | 4'(1 << n);
                    push(0, n, a, m_mem[a], t);
                end else begin
                    for (int i = 0; i < 4; i++)
                        if (m_sh[a][i] && i != n) push(1, i, a, 32'h0, t);
                    m_st[a] = 2;
                    m_sh[a] = 4'(1 << n);
                    push(0, n, a, m_mem[a], t);
                end
            end
            2: begin
                if (m_st[a] == 2 && m_sh[a][n]) begin
                    m_mem[a] = d;
                    m_st[a]  = 0;
                    m_sh[a]  = 4'h0;
                end
            end
            default: ;
        endcase
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            if (qk.size() > 0) begin
                chk(out_valid === 1'b1, qt[0], "out_valid", 64'(out_valid), 1);
                chk(out_kind == 2'(qk[0]), qt[0], "out_kind", 64'(out_kind), 64'(qk[0]));
                chk(out_node == 2'(qn[0]), qt[0], "out_node", 64'(out_node), 64'(qn[0]));
                chk(out_addr == 4'(qa[0]), "R10", "out_addr", 64'(out_addr), 64'(qa[0]));
                chk(out_data === qd[0], qt[0], "out_data", 64'(out_data), 64'(qd[0]));
                void'(qk.pop_front()); void'(qn.pop_front()); void'(qa.pop_front());
                void'(qd.pop_front()); void'(qt.pop_front());
            end else begin
                chk(out_valid === 1'b0, cur_tag, "idle out_valid", 64'(out_valid), 0);
            end
        end
    end

    task automatic issue(input int k, input int n, input int a,
                         input logic [31:0] d, input string t);
        bit er;
        while (qk.size() != 0) @(negedge clk);
        @(negedge clk);
        cur_tag  = t;
        in_valid = 1'b1;
        in_kind  = 2'(k);
        in_node  = 2'(n);
        in_addr  = 4'(a);
        in_data  = d;
        er = exp_ready(k, n, a);
        #1;
        chk(in_ready === er, er ? t : "R8", "in_ready", 64'(in_ready), 64'(er));
        if (er) begin
            @(posedge clk);
            model_accept(k, n, a, d, t);
            @(negedge clk);
        end else begin
            repeat (2) begin
                @(negedge clk);
                #1;
                chk(in_ready === 1'b0, "R8", "in_ready held", 64'(in_ready), 0);
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_T * 150000);
        bad++;
        $display("FAIL watchdog expired, all of R1 to R10 unfinished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        for (int i = 0; i < 16; i++) begin
            m_st[i]  = 0;
            m_sh[i]  = 4'h0;
            m_mem[i] = boot(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state at the ports
        chk(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
        chk(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);
        mon_on = 1;

        // R1 and R2: reads of untouched blocks return the boot word
        issue(0, 1, 3, 32'h0, "R1");
        issue(0, 2, 3, 32'h0, "R2");
        issue(0, 0, 3, 32'h0, "R2");
        // R4: invalidates to nodes 0 and 2, then reply to 1
        issue(1, 1, 3, 32'h0, "R4");
        // R9: write-back from a non-owner
        issue(2, 2, 3, 32'hDEAD_0001, "R9");
        // R5 with stray requests during the wait (R8)
        issue(0, 3, 3, 32'h0, "R5");
        issue(0, 0, 5, 32'h0, "R8");
        issue(2, 2, 3, 32'hDEAD_0002, "R8");
        issue(2, 1, 4, 32'hDEAD_0003, "R8");
        issue(2, 1, 3, 32'h1111_2222, "R5");
        // R4: requester already a sharer, only node 1 is invalidated
        issue(1, 3, 3, 32'h0, "R4");
        // R6: fetch-and-invalidate of owner 3
        issue(1, 0, 3, 32'h0, "R6");
        issue(2, 3, 3, 32'h3333_4444, "R6");
        // R7: owner write-back while idle, then read shows the new word
        issue(2, 0, 3, 32'h5555_6666, "R7");
        issue(0, 2, 3, 32'h0, "R7");
        // R9: write-back to a shared block is ignored
        issue(2, 2, 3, 32'h7777_0000, "R9");
        issue(0, 1, 3, 32'h0, "R9");
        // R3 then R6 on another block
        issue(1, 2, 7, 32'h0, "R3");
        issue(1, 1, 7, 32'h0, "R6");
        issue(2, 2, 7, 32'h0707_0707, "R6");
        issue(0, 3, 7, 32'h0, "R6");
        // R3 then R5 on block 9
        issue(1, 0, 9, 32'h0, "R3");
        issue(0, 1, 9, 32'h0, "R5");
        issue(2, 0, 9, 32'h0909_0909, "R5");
        // R4 boundary: sole sharer writes, reply without invalidates
        issue(0, 2, 10, 32'h0, "R2");
        issue(1, 2, 10, 32'h0, "R4");
        // R9: unused request code
        issue(3, 1, 10, 32'hFFFF_FFFF, "R9");
        issue(0, 1, 12, 32'h0, "R2");

        // mixed traffic on four blocks
        seed = 32'h1234_5678;
        for (int it = 0; it < 300; it++) begin
            int k, n, a;
            seed = seed * 1103515245 + 12345;
            k = (seed >>> 16) & 3;
            n = (seed >>> 20) & 3;
            a = (seed >>> 24) & 3;
            if (m_wait)
                issue(2, w_owner, w_addr, 32'(seed), "R5");
            else if (k == 0)
                issue(0, n, a, 32'h0, "R2");
            else if (k == 1)
                issue(1, n, a, 32'h0, "R4");
            else
                issue(2, n, a, 32'(seed), "R7");
        end
        while (qk.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule